// File: doc/BRIEF.md
# Serial Channel Command Decoder

This block sits behind the command register of one serial channel. Software writes an 8-bit command word, and the block turns it into one-cycle pulses and level changes. Those outputs go to the transmitter, the receiver, the counter/timer and the interrupt logic. The lower four bits of the word start or stop the transmitter and the receiver. The upper four bits hold a code that selects one of sixteen miscellaneous commands:

- mode-pointer moves
- datapath resets
- status and interrupt clears
- break start and stop
- RTS drive
- time-out mode
- power-down

The serial datapaths and the counter/timer are not part of this block. They see only its outputs.

Two small state machines shape the decoding.

The spacing guard has two states, `GAP_OPEN` and `GAP_HOLD`:
- `GAP_OPEN` → `GAP_HOLD` when an upper-nibble command is accepted.
- `GAP_HOLD` counts down the guard window.
- `GAP_HOLD` → `GAP_OPEN` when the countdown reaches its last cycle.

The power controller has two states, `PWR_RUN` and `PWR_DOWN`:
- `PWR_RUN` → `PWR_DOWN` on an accepted power-down entry command.
- `PWR_DOWN` → `PWR_RUN` on an accepted exit command.

All outputs are registered. A write sampled on clock edge t shows its effect in the cycle that follows edge t.

Top module: `ucmd_decoder`

## Requirements
- R1: The lower bits of a written word act as follows: bit 3 stops the transmitter, bit 2 starts the transmitter, bit 1 stops the receiver, bit 0 starts the receiver. Each set bit yields a one-cycle pulse on `tx_disable_p`, `tx_enable_p`, `rx_disable_p` or `rx_enable_p` in the cycle after the write edge. Several such bits in one word act together.
- R2: A word that sets both the start and stop bit of the same direction produces only the stop pulse for that direction. It also sets `conflict_flag`, which stays high until reset.
- R3: An accepted upper code c (bits 7..4) produces a one-cycle pulse on `misc_pulse[c]` in the cycle after the write. The codes are: 1 pointer to MR1, 2 receiver reset, 3 transmitter reset, 4 clear error status, 5 clear break-change interrupt, 6 start break, 7 stop break, 8 RTS low, 9 RTS high, 10 time-out mode on, 11 pointer to MR0, 12 time-out mode off, 14 power-down entry, 15 power-down exit. Codes 0 and 13 produce no pulse.
- R4: After an upper command is accepted on edge t, any upper command (code other than 0 or 13) written on edges t+1 to t+MIN_GAP-1 is dropped. Such a drop sets `gap_violation`, which stays high until reset. A command on edge t+MIN_GAP is accepted. The lower bits of a word whose upper command was dropped still act. Codes 0 and 13 neither open a window nor cause a violation.
- R5: Code 1 sets `mr_ptr_sel` to 1 (MR1). Code 11 sets it to 0 (MR0).
- R6: Code 8 drives `rts_n` low. Code 9 drives it high.
- R7: Code 10 sets `timeout_mode`. Code 12 clears it.
- R8: Code 14 sets `power_down` and code 15 clears it. While `power_down` is high, any word whose code is not 15 is ignored completely: no pulse, no level change, no violation, no guard window. The lower bits of every word are also ignored while `power_down` is high, including the word carrying code 15. Code 15 itself is still subject to the spacing rule.
- R9: After reset all pulses are low, `mr_ptr_sel`, `timeout_mode`, `power_down`, `conflict_flag` and `gap_violation` are 0, and `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe, sampled on the rising edge |
| wr_data | input | 8 | Command word |
| tx_enable_p | output | 1 | Transmitter start pulse |
| tx_disable_p | output | 1 | Transmitter stop pulse |
| rx_enable_p | output | 1 | Receiver start pulse |
| rx_disable_p | output | 1 | Receiver stop pulse |
| misc_pulse | output | 16 | One-hot pulse, indexed by the accepted upper code |
| mr_ptr_sel | output | 1 | Mode pointer select, 1 = MR1, 0 = MR0 |
| rts_n | output | 1 | Request-to-send, active low |
| timeout_mode | output | 1 | Time-out mode level |
| power_down | output | 1 | Power-down level |
| conflict_flag | output | 1 | Sticky start/stop conflict flag |
| gap_violation | output | 1 | Sticky spacing violation flag |

## Verification
The assertions check several things on every cycle:
- `misc_pulse` is one-hot or zero.
- Codes 0 and 13 never pulse.
- Two upper-nibble pulses never occur back to back.
- Start and stop of one direction never pulse together.
- Each level output agrees with the pulse that set it.
- Nothing but the exit command acts while power-down is held.
- Both flags are sticky.

Only the bench scenarios can show the cycle counts and the exemptions. These include the exact edge at which the guard window reopens, the fact that codes 0 and 13 leave the window untouched, and the fact that the lower bits of a word with a dropped command still act. They also include the full ignore behaviour across a power-down stretch.

// File: rtl/ucmd_pkg.sv
package ucmd_pkg;

    localparam int WORD_W   = 8;
    localparam int CODE_W   = 4;
    localparam int NUM_CODE = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP         = 4'd0,
        CMD_MR_TO_1     = 4'd1,
        CMD_RX_RESET    = 4'd2,
        CMD_TX_RESET    = 4'd3,
        CMD_CLR_ERR     = 4'd4,
        CMD_CLR_BRK_INT = 4'd5,
        CMD_BRK_START   = 4'd6,
        CMD_BRK_STOP    = 4'd7,
        CMD_RTS_LOW     = 4'd8,
        CMD_RTS_HIGH    = 4'd9,
        CMD_TMO_ON      = 4'd10,
        CMD_MR_TO_0     = 4'd11,
        CMD_TMO_OFF     = 4'd12,
        CMD_SPARE       = 4'd13,
        CMD_PD_ENTER    = 4'd14,
        CMD_PD_EXIT     = 4'd15
    } misc_cmd_e;

    typedef enum logic {
        GAP_OPEN,
        GAP_HOLD
    } gap_state_e;

    typedef enum logic {
        PWR_RUN,
        PWR_DOWN
    } pwr_state_e;

    typedef struct packed {
        logic tx_dis;
        logic tx_en;
        logic rx_dis;
        logic rx_en;
    } dir_cmd_t;

endpackage

// File: rtl/ucmd_word_decode.sv
module ucmd_word_decode
    import ucmd_pkg::*;
(
    input  logic                  wr_en,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  pd_active,
    output dir_cmd_t              dir_cmd,
    output logic                  conflict_evt,
    output logic                  upper_req,
    output misc_cmd_e             code
);

    logic      low_ok;
    logic      is_cmd;
    logic      allowed;
    dir_cmd_t  raw;

    always_comb begin
        code    = misc_cmd_e'(wr_data[WORD_W-1 -: CODE_W]);
        low_ok  = wr_en && !pd_active;
        raw     = dir_cmd_t'(wr_data[3:0]);

        is_cmd  = (code != CMD_NOP) && (code != CMD_SPARE);
        allowed = !pd_active || (code == CMD_PD_EXIT);
        upper_req = wr_en && is_cmd && allowed;

        dir_cmd.tx_dis = low_ok && raw.tx_dis;
        dir_cmd.tx_en  = low_ok && raw.tx_en && !raw.tx_dis;
        dir_cmd.rx_dis = low_ok && raw.rx_dis;
        dir_cmd.rx_en  = low_ok && raw.rx_en && !raw.rx_dis;

        conflict_evt = low_ok && ((raw.tx_dis && raw.tx_en) ||
                                  (raw.rx_dis && raw.rx_en));
    end

endmodule

// File: rtl/ucmd_gap_guard.sv
module ucmd_gap_guard
    import ucmd_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic violate
);

    localparam int CW = $clog2(MIN_GAP + 1);

    gap_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GAP_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GAP_OPEN: begin
                if (req) begin
                    state_d = GAP_HOLD;
                    cnt_d   = CW'(MIN_GAP - 1);
                end
            end
            GAP_HOLD: begin
                if (cnt_q <= CW'(1)) begin
                    state_d = GAP_OPEN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
        endcase
    end

    always_comb begin
        ready   = (state_q == GAP_OPEN);
        accept  = req && ready;
        violate = req && !ready;
    end

    initial begin
        assert (MIN_GAP >= 2) else $error("MIN_GAP must be at least 2");
    end

    assert_hold_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

    assert_hold_counts_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GAP_HOLD && cnt_q > CW'(1)) |=> (state_q == GAP_HOLD && cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/ucmd_pwr_ctl.sv
module ucmd_pwr_ctl
    import ucmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    output logic pd_active
);

    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:  if (enter) state_d = PWR_DOWN;
            PWR_DOWN: if (leave) state_d = PWR_RUN;
        endcase
    end

    assign pd_active = (state_q == PWR_DOWN);

    assert_pd_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> pd_active);

    assert_pd_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> !pd_active);

endmodule

// File: rtl/ucmd_decoder.sv
module ucmd_decoder
    import ucmd_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic                 tx_enable_p,
    output logic                 tx_disable_p,
    output logic                 rx_enable_p,
    output logic                 rx_disable_p,
    output logic [15:0]          misc_pulse,
    output logic                 mr_ptr_sel,
    output logic                 rts_n,
    output logic                 timeout_mode,
    output logic                 power_down,
    output logic                 conflict_flag,
    output logic                 gap_violation
);

    dir_cmd_t             dir_cmd;
    logic                 conflict_evt;
    logic                 upper_req;
    misc_cmd_e            code;
    logic                 accept;
    logic                 violate;
    logic                 pd_active;
    logic [NUM_CODE-1:0]  misc_d;

    ucmd_word_decode u_decode (
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .pd_active    (pd_active),
        .dir_cmd      (dir_cmd),
        .conflict_evt (conflict_evt),
        .upper_req    (upper_req),
        .code         (code)
    );

    ucmd_gap_guard #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (upper_req),
        .accept  (accept),
        .violate (violate)
    );

    ucmd_pwr_ctl u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (misc_d[CMD_PD_ENTER]),
        .leave     (misc_d[CMD_PD_EXIT]),
        .pd_active (pd_active)
    );

    for (genvar i = 0; i < NUM_CODE; i++) begin : g_misc
        assign misc_d[i] = accept && (code == misc_cmd_e'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_enable_p   <= 1'b0;
            tx_disable_p  <= 1'b0;
            rx_enable_p   <= 1'b0;
            rx_disable_p  <= 1'b0;
            misc_pulse    <= '0;
            mr_ptr_sel    <= 1'b0;
            rts_n         <= 1'b1;
            timeout_mode  <= 1'b0;
            conflict_flag <= 1'b0;
            gap_violation <= 1'b0;
        end else begin
            tx_enable_p  <= dir_cmd.tx_en;
            tx_disable_p <= dir_cmd.tx_dis;
            rx_enable_p  <= dir_cmd.rx_en;
            rx_disable_p <= dir_cmd.rx_dis;
            misc_pulse   <= misc_d;
            if (misc_d[CMD_MR_TO_1])  mr_ptr_sel   <= 1'b1;
            if (misc_d[CMD_MR_TO_0])  mr_ptr_sel   <= 1'b0;
            if (misc_d[CMD_RTS_LOW])  rts_n        <= 1'b0;
            if (misc_d[CMD_RTS_HIGH]) rts_n        <= 1'b1;
            if (misc_d[CMD_TMO_ON])   timeout_mode <= 1'b1;
            if (misc_d[CMD_TMO_OFF])  timeout_mode <= 1'b0;
            if (conflict_evt)         conflict_flag <= 1'b1;
            if (violate)              gap_violation <= 1'b1;
        end
    end

    assign power_down = pd_active;

    assert_misc_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(misc_pulse));

    assert_no_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !misc_pulse[CMD_NOP] && !misc_pulse[CMD_SPARE]);

    assert_misc_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_pulse != '0) |=> (misc_pulse == '0));

    assert_tx_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_enable_p && tx_disable_p));

    assert_rx_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_enable_p && rx_disable_p));

    assert_conflict_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_flag |=> conflict_flag);

    assert_violation_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_violation |=> gap_violation);

    assert_mr_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_MR_TO_1] |-> mr_ptr_sel);

    assert_mr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_MR_TO_0] |-> !mr_ptr_sel);

    assert_rts_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_RTS_LOW] |-> !rts_n);

    assert_rts_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_RTS_HIGH] |-> rts_n);

    assert_tmo_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_TMO_ON] |-> timeout_mode);

    assert_tmo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        misc_pulse[CMD_TMO_OFF] |-> !timeout_mode);

    assert_pd_silence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(power_down) |-> (misc_pulse[14:0] == '0 && !tx_enable_p && !tx_disable_p &&
                               !rx_enable_p && !rx_disable_p && $stable(rts_n) &&
                               $stable(mr_ptr_sel) && $stable(timeout_mode)));

endmodule

// File: tb/ucmd_decoder_test.sv
module ucmd_decoder_test;

    localparam int MIN_GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        tx_enable_p, tx_disable_p, rx_enable_p, rx_disable_p;
    logic [15:0] misc_pulse;
    logic        mr_ptr_sel, rts_n, timeout_mode, power_down, conflict_flag, gap_violation;

    int checks = 0;
    int failures = 0;

    int gap_left = 0;
    bit m_pd = 0, m_rts = 1, m_mr = 0, m_tmo = 0, m_conf = 0, m_viol = 0;

    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    ucmd_decoder #(.MIN_GAP(MIN_GAP)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .tx_enable_p   (tx_enable_p),
        .tx_disable_p  (tx_disable_p),
        .rx_enable_p   (rx_enable_p),
        .rx_disable_p  (rx_disable_p),
        .misc_pulse    (misc_pulse),
        .mr_ptr_sel    (mr_ptr_sel),
        .rts_n         (rts_n),
        .timeout_mode  (timeout_mode),
        .power_down    (power_down),
        .conflict_flag (conflict_flag),
        .gap_violation (gap_violation)
    );

    function automatic logic [25:0] observe();
        return {tx_enable_p, tx_disable_p, rx_enable_p, rx_disable_p, misc_pulse,
                mr_ptr_sel, rts_n, timeout_mode, power_down, conflict_flag, gap_violation};
    endfunction

    task automatic compare(input logic [25:0] exp, input string tag);
        logic [25:0] act;
        act = observe();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] d, input string tag);
        logic [3:0]  code;
        bit          upper_req, acc, low_ok;
        bit          etx_en, etx_dis, erx_en, erx_dis;
        logic [15:0] emisc;
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        code = d[7:4];
        upper_req = we && code != 4'd0 && code != 4'd13 && (!m_pd || code == 4'd15);
        acc = upper_req && gap_left == 0;
        if (upper_req && gap_left > 0) m_viol = 1;
        low_ok  = we && !m_pd;
        etx_dis = low_ok && d[3];
        etx_en  = low_ok && d[2] && !d[3];
        erx_dis = low_ok && d[1];
        erx_en  = low_ok && d[0] && !d[1];
        if (low_ok && ((d[3] && d[2]) || (d[1] && d[0]))) m_conf = 1;
        emisc = acc ? (16'd1 << code) : 16'd0;
        if (acc) begin
            case (code)
                4'd1:  m_mr  = 1;
                4'd11: m_mr  = 0;
                4'd8:  m_rts = 0;
                4'd9:  m_rts = 1;
                4'd10: m_tmo = 1;
                4'd12: m_tmo = 0;
                4'd14: m_pd  = 1;
                4'd15: m_pd  = 0;
                default: ;
            endcase
            gap_left = MIN_GAP - 1;
        end else if (gap_left > 0) begin
            gap_left--;
        end
        exp_q.push_back({etx_en, etx_dis, erx_en, erx_dis, emisc,
                         m_mr, m_rts, m_tmo, m_pd, m_conf, m_viol});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 8'h00, tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            logic [25:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        compare({4'b0, 16'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, "R9 reset state");

        step(1, 8'h05, "R1 start tx and rx");
        step(1, 8'h0A, "R1 stop tx and rx");
        step(1, 8'h04, "R1 start tx only");
        step(1, 8'h02, "R1 stop rx only");
        step(1, 8'h10, "R5 pointer to MR1");
        step(1, 8'hD0, "R4 spare code ignored in window");
        step(1, 8'h00, "R4 nop ignored in window");
        step(1, 8'h80, "R6 rts low at window edge");
        idle(2, "R4 idle");
        step(1, 8'hB0, "R5 pointer to MR0");
        step(1, 8'h91, "R4 dropped code, lower bits act");
        step(1, 8'h90, "R4 second drop");
        step(1, 8'h90, "R6 rts high after window");
        idle(2, "R3 idle");
        for (int c = 2; c <= 7; c++) begin
            step(1, 8'(c << 4), "R3 misc code pulse");
            idle(2, "R3 idle");
        end
        step(1, 8'h0C, "R2 tx conflict");
        step(1, 8'h03, "R2 rx conflict");
        step(1, 8'hA0, "R7 timeout on");
        idle(2, "R7 idle");
        step(1, 8'hC0, "R7 timeout off");
        idle(2, "R7 idle");
        step(1, 8'h86, "R6 rts low with lower bits");
        idle(2, "R8 idle");
        step(1, 8'hE0, "R8 enter power down");
        idle(2, "R8 idle");
        step(1, 8'h95, "R8 ignored while down");
        step(1, 8'h10, "R8 ignored, no window");
        step(1, 8'hA5, "R8 ignored again");
        step(1, 8'hF5, "R8 exit, lower bits ignored");
        step(1, 8'h90, "R8 exit opens window");
        idle(2, "R8 idle");
        step(1, 8'h90, "R6 rts high after exit");
        step(1, 8'hE0, "R4 enter inside window");
        idle(2, "R8 idle");
        step(1, 8'hF0, "R8 exit command");
        step(1, 8'hF0, "R8 exit repeat in window");
        idle(3, "R9 drain");
        wait (exp_q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule